// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block sits between a processor's sleep command and the clock tree. When the command arrives, the block takes the 2-bit mode field and moves into one of four low-power states. Each state has its own pattern of enables for five clocks: the CPU, flash, I/O and ADC clock domains and the main oscillator. Each state also has its own set of wake-up sources that are allowed to end it.

Idle and ADC noise reduction end at once when an allowed source arrives. Power-down and standby first pass through a wake-up delay. During that delay only the oscillator runs. Power-down counts a selectable number of ticks of a free-running slow clock. Standby counts a fixed number of system clock cycles. The block also does two side jobs. It raises a one-cycle ADC start pulse when a sleep that keeps the ADC clock running begins. It raises an input-buffer disable whenever the I/O and ADC clocks are both stopped.

Top module: `slp_clk_ctrl`

## Requirements
- R1: After reset the block is running: all five clock enables are 1, and `adc_start` and `inbuf_off` are 0.
- R2: Mode 00 (idle) turns off the CPU and flash clocks and keeps I/O, ADC and oscillator on. Any wake source (bits 0..6) ends it, and all clocks are on one cycle after the source is sampled.
- R3: Mode 01 (ADC noise reduction) turns off the CPU, flash and I/O clocks and keeps ADC and oscillator on. Wake bits 0..5 end it at once. Bit 6 (other peripheral) is ignored.
- R4: Mode 10 (power-down) turns off all four domains and the oscillator. Only wake bits 0..3 (reset, serial start, low-level interrupt, pin change) end it.
- R5: Mode 11 (standby) has the same domains and wake sources as power-down but keeps the oscillator on. When `xtal_sel` is 0 it acts exactly as power-down.
- R6: A wake from standby spends STBY_CYC (6) cycles with only the oscillator enabled, then turns all clocks on.
- R7: A wake from power-down keeps only the oscillator enabled for PD_BASE<<(2*`pd_dly_sel`) slow ticks (4, 16, 64 or 256). All clocks come on in the cycle after the last tick is sampled.
- R8: Entering idle or ADC noise reduction while `adc_on` is 1 gives a single-cycle `adc_start` in the first sleeping cycle. There is no pulse otherwise.
- R9: `inbuf_off` is 1 exactly when the I/O and ADC clock enables are both 0.
- R10: If a wake source allowed in the requested mode is active together with the sleep command, sleep is skipped and all clocks stay on. A source that the requested mode does not allow does not block sleep.
- R11: While sleeping, `sleep_req` and changes of `mode_sel` have no effect on the clock enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Sleep command, sampled while running |
| mode_sel | input | 2 | Requested sleep mode: 00 idle, 01 ADC noise reduction, 10 power-down, 11 standby |
| xtal_sel | input | 1 | 1 when an external crystal or resonator drives the main clock |
| adc_on | input | 1 | ADC enabled |
| pd_dly_sel | input | 2 | Power-down wake delay select |
| slow_tick | input | 1 | One-cycle pulse from the free-running slow clock |
| wake_src | input | 7 | Wake sources: 0 reset, 1 serial start, 2 low-level interrupt, 3 pin change, 4 EEPROM ready, 5 ADC done, 6 other peripheral |
| cpu_clk_en | output | 1 | CPU clock enable |
| flash_clk_en | output | 1 | Flash clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| adc_clk_en | output | 1 | ADC clock enable |
| osc_en | output | 1 | Main oscillator enable |
| adc_start | output | 1 | ADC conversion start pulse |
| inbuf_off | output | 1 | Digital input buffer disable |

## Verification
The assertions assume that every input, including `slow_tick`, is synchronous to `clk`. They also assume that `slow_tick` is a one-cycle pulse that does not stay high across consecutive ticks. The bench changes every input on the falling edge, so each one is stable at the rising edge that samples it. It drives ticks either from a divide-by-four generator or by hand, one pulse at a time. Wake sources are held for a single cycle and then dropped, so any wake that happens later comes from the latched state and not from a source that is still active.

// File: rtl/slp_pkg.sv
package slp_pkg;
    localparam int NSRC     = 7;
    localparam int SRC_PCHG = 3;
    localparam int SRC_ADC  = 5;

    typedef enum logic [1:0] {
        M_IDLE  = 2'b00,
        M_ADCNR = 2'b01,
        M_PDOWN = 2'b10,
        M_STBY  = 2'b11
    } slp_mode_e;

    typedef enum logic [1:0] {
        S_RUN   = 2'b00,
        S_SLEEP = 2'b01,
        S_WAKE  = 2'b10
    } slp_state_e;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
        logic adc;
        logic osc;
    } clk_mask_t;
endpackage

// File: rtl/slp_mode_decode.sv
module slp_mode_decode
    import slp_pkg::*;
(
    input  slp_mode_e         mode,
    output clk_mask_t         mask,
    output logic [NSRC-1:0]   wake_ok
);
    always_comb begin
        mask = '0;
        unique case (mode)
            M_IDLE:  begin mask.io = 1'b1; mask.adc = 1'b1; mask.osc = 1'b1; end
            M_ADCNR: begin mask.adc = 1'b1; mask.osc = 1'b1; end
            M_PDOWN: mask = '0;
            M_STBY:  mask.osc = 1'b1;
            default: mask = '0;
        endcase
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam bit IN_NR = (i <= SRC_ADC);
        localparam bit IN_PD = (i <= SRC_PCHG);
        assign wake_ok[i] = IN_PD || (mode == M_IDLE) || (IN_NR && mode == M_ADCNR);
    end
endmodule

// File: rtl/slp_wake_timer.sv
module slp_wake_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             load_slow,
    input  logic [CNT_W-1:0] load_val,
    input  logic             slow_tick,
    output logic             expire
);
    typedef struct packed {
        logic             active;
        logic             slow;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic step;

    always_comb begin
        step   = tmr_q.slow ? slow_tick : 1'b1;
        expire = tmr_q.active && step && (tmr_q.cnt == '0);
        tmr_d  = tmr_q;
        if (load) begin
            tmr_d.active = 1'b1;
            tmr_d.slow   = load_slow;
            tmr_d.cnt    = load_val;
        end else if (tmr_q.active && step) begin
            if (tmr_q.cnt == '0) tmr_d.active = 1'b0;
            else                 tmr_d.cnt    = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R7: a slow-clocked count only moves on a tick
    a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.active && tmr_q.slow && !slow_tick && !load) |=> $stable(tmr_q.cnt));
    // R6: expiry ends the count
    a_r6_expire_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !load) |=> !tmr_q.active);
endmodule

// File: rtl/slp_clk_ctrl.sv
module slp_clk_ctrl
    import slp_pkg::*;
#(
    parameter int STBY_CYC = 6,
    parameter int PD_BASE  = 4,
    parameter int CNT_W    = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_req,
    input  logic [1:0]      mode_sel,
    input  logic            xtal_sel,
    input  logic            adc_on,
    input  logic [1:0]      pd_dly_sel,
    input  logic            slow_tick,
    input  logic [6:0]      wake_src,
    output logic            cpu_clk_en,
    output logic            flash_clk_en,
    output logic            io_clk_en,
    output logic            adc_clk_en,
    output logic            osc_en,
    output logic            adc_start,
    output logic            inbuf_off
);
    localparam logic [CNT_W-1:0] STBY_LOAD = CNT_W'(STBY_CYC - 1);
    localparam logic [CNT_W-1:0] PD_UNIT   = CNT_W'(PD_BASE);

    typedef struct packed {
        slp_state_e st;
        slp_mode_e  mode;
        logic       go;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    slp_mode_e        mode_eff;
    clk_mask_t        req_mask, cur_mask, ce;
    logic [NSRC-1:0]  req_ok, cur_ok;
    logic             tmr_load, tmr_slow, tmr_expire;
    logic [CNT_W-1:0] tmr_val, pd_len;

    assign mode_eff = (slp_mode_e'(mode_sel) == M_STBY && !xtal_sel) ? M_PDOWN
                                                                     : slp_mode_e'(mode_sel);
    assign pd_len   = PD_UNIT << {pd_dly_sel, 1'b0};

    slp_mode_decode u_req_dec (.mode(mode_eff),   .mask(req_mask), .wake_ok(req_ok));
    slp_mode_decode u_cur_dec (.mode(ctl_q.mode), .mask(cur_mask), .wake_ok(cur_ok));

    slp_wake_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_slow(tmr_slow),
        .load_val(tmr_val), .slow_tick(slow_tick), .expire(tmr_expire)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.go = 1'b0;
        tmr_load = 1'b0;
        tmr_slow = 1'b0;
        tmr_val  = '0;
        unique case (ctl_q.st)
            S_RUN: begin
                if (sleep_req && !(|(wake_src & req_ok))) begin
                    ctl_d.st   = S_SLEEP;
                    ctl_d.mode = mode_eff;
                    ctl_d.go   = adc_on && req_mask.adc;
                end
            end
            S_SLEEP: begin
                if (|(wake_src & cur_ok)) begin
                    if (ctl_q.mode == M_PDOWN) begin
                        ctl_d.st = S_WAKE;
                        tmr_load = 1'b1;
                        tmr_slow = 1'b1;
                        tmr_val  = pd_len - 1'b1;
                    end else if (ctl_q.mode == M_STBY) begin
                        ctl_d.st = S_WAKE;
                        tmr_load = 1'b1;
                        tmr_val  = STBY_LOAD;
                    end else begin
                        ctl_d.st = S_RUN;
                    end
                end
            end
            S_WAKE: begin
                if (tmr_expire) ctl_d.st = S_RUN;
            end
            default: ctl_d.st = S_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: S_RUN, mode: M_IDLE, go: 1'b0};
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        unique case (ctl_q.st)
            S_SLEEP: ce = cur_mask;
            S_WAKE:  ce = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b1};
            default: ce = '1;
        endcase
    end

    assign cpu_clk_en   = ce.cpu;
    assign flash_clk_en = ce.flash;
    assign io_clk_en    = ce.io;
    assign adc_clk_en   = ce.adc;
    assign osc_en       = ce.osc;
    assign adc_start    = ctl_q.go;
    assign inbuf_off    = !ce.io && !ce.adc;

    // R1: CPU clock only runs with every other clock running
    a_r1_cpu_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> (flash_clk_en && io_clk_en && adc_clk_en && osc_en));
    // R4: a stopped oscillator means every domain is stopped
    a_r4_osc_off_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !(cpu_clk_en || flash_clk_en || io_clk_en || adc_clk_en));
    // R6: during a wake delay only the oscillator runs
    a_r6_wake_osc_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_WAKE) |-> (osc_en && !cpu_clk_en && !io_clk_en));
    // R8: start pulse lasts one cycle and only while sleeping with ADC clock on
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);
    a_r8_pulse_context: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (ctl_q.st == S_SLEEP && adc_clk_en && !cpu_clk_en));
    // R9: buffers only disabled with both I/O and ADC clocks off
    a_r9_inbuf_off: assert property (@(posedge clk) disable iff (!rst_n)
        inbuf_off |-> (!io_clk_en && !adc_clk_en));
    // R10: an allowed active source cancels the sleep command
    a_r10_skip_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_RUN && sleep_req && |(wake_src & req_ok)) |=> cpu_clk_en);
    // R11: without an allowed source the sleep state and its mode hold
    a_r11_hold_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_SLEEP && !(|(wake_src & cur_ok)))
            |=> (ctl_q.st == S_SLEEP && $stable(ctl_q.mode)));
endmodule

// File: tb/slp_clk_ctrl_bench.sv
module slp_clk_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;

    typedef struct packed {
        logic [1:0] mode;
        logic       xtal;
        logic       adc;
        logic [6:0] wk;
        logic [4:0] smask;   // {cpu,flash,io,adc,osc}
        logic       go;
        logic       wakes;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'b00, 1'b0, 1'b1, 7'b1000000, 5'b00111, 1'b1, 1'b1},
        '{2'b00, 1'b0, 1'b0, 7'b0010000, 5'b00111, 1'b0, 1'b1},
        '{2'b01, 1'b0, 1'b1, 7'b1000000, 5'b00011, 1'b1, 1'b0},
        '{2'b01, 1'b0, 1'b0, 7'b0100000, 5'b00011, 1'b0, 1'b1},
        '{2'b01, 1'b0, 1'b1, 7'b0010000, 5'b00011, 1'b1, 1'b1},
        '{2'b10, 1'b0, 1'b1, 7'b0100000, 5'b00000, 1'b0, 1'b0},
        '{2'b10, 1'b0, 1'b0, 7'b0001000, 5'b00000, 1'b0, 1'b1},
        '{2'b10, 1'b1, 1'b0, 7'b0010000, 5'b00000, 1'b0, 1'b0},
        '{2'b11, 1'b1, 1'b1, 7'b0000010, 5'b00001, 1'b0, 1'b1},
        '{2'b11, 1'b1, 1'b0, 7'b1000000, 5'b00001, 1'b0, 1'b0},
        '{2'b11, 1'b0, 1'b0, 7'b0000100, 5'b00000, 1'b0, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic sleep_req = 1'b0, xtal_sel = 1'b0, adc_on = 1'b0;
    logic [1:0] mode_sel = 2'b00, pd_dly_sel = 2'b00;
    logic [6:0] wake_src = '0;
    logic tick_auto = 1'b1, tick_man = 1'b0, auto_t = 1'b0, slow_tick;
    logic [1:0] div = '0;
    logic cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, osc_en, adc_start, inbuf_off;
    logic [4:0] ce_v;
    int total = 0, fails = 0, cyc = 0;
    string mreq [4] = '{"R2", "R3", "R4", "R5"};

    assign slow_tick = tick_auto ? auto_t : tick_man;
    assign ce_v = {cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, osc_en};

    slp_clk_ctrl u_slp_clk_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .mode_sel(mode_sel),
        .xtal_sel(xtal_sel), .adc_on(adc_on), .pd_dly_sel(pd_dly_sel),
        .slow_tick(slow_tick), .wake_src(wake_src),
        .cpu_clk_en(cpu_clk_en), .flash_clk_en(flash_clk_en), .io_clk_en(io_clk_en),
        .adc_clk_en(adc_clk_en), .osc_en(osc_en), .adc_start(adc_start), .inbuf_off(inbuf_off)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial forever begin
        @(negedge clk);
        div    = div + 1'b1;
        auto_t = (div == 2'b00);
    end

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                total++; fails++;
                $display("FAIL watchdog: actual %0d expected below %0d", cyc, 100000);
                summary();
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic go_sleep(input logic [1:0] m, input logic x, input logic a);
        mode_sel = m; xtal_sel = x; adc_on = a; sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    task automatic wait_run();
        for (int k = 0; k < 3000 && !cpu_clk_en; k++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ce_v == 5'b11111, "R1", ce_v, 5'b11111);
        chk(adc_start == 1'b0 && inbuf_off == 1'b0, "R1", {adc_start, inbuf_off}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            go_sleep(VECS[i].mode, VECS[i].xtal, VECS[i].adc);
            chk(ce_v == VECS[i].smask, mreq[VECS[i].mode], ce_v, VECS[i].smask);
            chk(adc_start == VECS[i].go, "R8", adc_start, VECS[i].go);
            chk(inbuf_off == (!VECS[i].smask[2] && !VECS[i].smask[1]), "R9",
                inbuf_off, (!VECS[i].smask[2] && !VECS[i].smask[1]));
            @(negedge clk);
            chk(adc_start == 1'b0, "R8", adc_start, 0);
            wake_src = VECS[i].wk;
            @(negedge clk);
            wake_src = '0;
            if (!VECS[i].wakes)
                chk(ce_v == VECS[i].smask, mreq[VECS[i].mode], ce_v, VECS[i].smask);
            else if (VECS[i].mode[1] == 1'b0)
                chk(ce_v == 5'b11111, mreq[VECS[i].mode], ce_v, 5'b11111);
            else
                chk(ce_v == 5'b00001, mreq[VECS[i].mode], ce_v, 5'b00001);
            if (!VECS[i].wakes) begin
                wake_src = 7'b0000001;
                @(negedge clk);
                wake_src = '0;
            end
            wait_run();
            chk(ce_v == 5'b11111, mreq[VECS[i].mode], ce_v, 5'b11111);
        end

        // R10: allowed source active at the command cancels sleep
        wake_src = 7'b0000001;
        go_sleep(2'b00, 1'b0, 1'b1);
        chk(ce_v == 5'b11111 && adc_start == 1'b0, "R10", ce_v, 5'b11111);
        // R10: source not allowed in the mode does not block sleep
        wake_src = 7'b1000000;
        go_sleep(2'b01, 1'b0, 1'b0);
        chk(ce_v == 5'b00011, "R10", ce_v, 5'b00011);
        wake_src = 7'b0000001;
        @(negedge clk);
        wake_src = '0;
        chk(ce_v == 5'b11111, "R3", ce_v, 5'b11111);

        // R11: commands and mode changes while asleep are ignored
        go_sleep(2'b10, 1'b0, 1'b0);
        mode_sel = 2'b00; sleep_req = 1'b1;
        repeat (3) @(negedge clk);
        sleep_req = 1'b0;
        chk(ce_v == 5'b00000, "R11", ce_v, 5'b00000);
        wake_src = 7'b0000001;
        @(negedge clk);
        wake_src = '0;
        wait_run();

        // R6: standby wake lasts six cycles
        go_sleep(2'b11, 1'b1, 1'b0);
        wake_src = 7'b0000010;
        @(negedge clk);
        wake_src = '0;
        chk(ce_v == 5'b00001, "R6", ce_v, 5'b00001);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(ce_v == 5'b00001, "R6", ce_v, 5'b00001);
        end
        @(negedge clk);
        chk(ce_v == 5'b11111, "R6", ce_v, 5'b11111);

        // R7: power-down delay per select value
        tick_auto = 1'b0;
        for (int s = 0; s < 4; s++) begin
            pd_dly_sel = 2'(s);
            go_sleep(2'b10, 1'b0, 1'b0);
            wake_src = 7'b0001000;
            @(negedge clk);
            wake_src = '0;
            for (int k = 0; k < (4 << (2 * s)) - 1; k++) begin
                tick_man = 1'b1;
                @(negedge clk);
                tick_man = 1'b0;
                @(negedge clk);
            end
            chk(ce_v == 5'b00001, "R7", ce_v, 5'b00001);
            tick_man = 1'b1;
            @(negedge clk);
            tick_man = 1'b0;
            chk(ce_v == 5'b11111, "R7", ce_v, 5'b11111);
        end
        summary();
    end
endmodule